// File: doc/BRIEF.md
# Iterative AES-128 Encryption Core

This block encrypts one 128-bit plaintext block under a 128-bit cipher key. It has one round datapath, and that datapath is reused on every clock until the block is done. The round keys are not held in a table. A small key register steps forward one round key per clock, in parallel with the data, and each new key feeds the round that uses it.

A one-cycle `start` pulse captures the plaintext and the key. The initial key addition is applied on that same edge. Ten more clock edges run the nine full rounds and then the final round, which skips the column mix. After the last of those edges, `done` is high for exactly one cycle. The ciphertext is on `cipherOut` in that cycle, and it stays there until the next accepted start.

Bytes are numbered from the most significant end: byte 0 is bits [127:120]. The 16 bytes fill the 4x4 state column by column, so byte n is row n mod 4 of column n div 4. The key uses the same ordering.

Top module: `aes128_iter_core`

## Requirements
- R1: While reset is asserted and afterwards, `done` is low. Without an accepted `start`, `done` never rises.
- R2: With bits [127:120] as the first byte of both key and block, the value on `cipherOut` when `done` is high equals standard AES-128 encryption of `plainIn` under `keyIn`. This includes the published known-answer vectors.
- R3: The clock edge that samples `start` high while idle is edge 0. `done` is first high after edge 10, so a run occupies eleven clock cycles, and `done` is never high earlier.
- R4: `done` stays high for one clock cycle only.
- R5: A `start` pulse that arrives while an encryption is running has no effect. It changes neither the result nor the cycle in which `done` appears.
- R6: After `done`, `cipherOut` keeps the ciphertext unchanged until the next accepted `start`.
- R7: A `start` given in the same cycle as `done` is accepted. Encryptions can therefore follow one another every eleven cycles.
- R8: Each round key is derived in the clock where it is used, from the previous round key. The last key word is rotated by one byte, passed through the S-box and XORed with a round constant, and the result is then chained by XOR through all four words. The round constant is 0x01 for round 1 and doubles in GF(2^8) each round, so round 10 uses 0x36.
- R9: `plainIn` and `keyIn` are sampled only on the edge that accepts `start`. Changing them later during the run does not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins an encryption when the core is idle |
| plainIn | input | 128 | Plaintext block, sampled at an accepted start |
| keyIn | input | 128 | Cipher key, sampled at an accepted start |
| cipherOut | output | 128 | Ciphertext, valid from the cycle `done` is high |
| done | output | 1 | One-cycle pulse marking a finished encryption |

## Verification
The hardest situations to reach from the ports are a start that lands while a run is already in progress, and a start that lands exactly in the one cycle where `done` is high. To cover the first, the bench holds `start` high through a whole run and puts new data on the inputs. It then checks that the ciphertext and the cycle of `done` both match an undisturbed run. To cover the second, the bench chains two encryptions, placing the second `start` in the `done` cycle of the first. Around both cases, a sweep of random key and plaintext pairs is compared against an arithmetic AES model inside the bench. That model uses a brute-force inverse S-box and is anchored on three known-answer vectors, which exercises the round-constant sequence and every byte position.

// File: rtl/aes_iter_pkg.sv
package aes_iter_pkg;

  localparam int BLOCK_W     = 128;
  localparam int BYTE_W      = 8;
  localparam int WORD_W      = 32;
  localparam int NUM_BYTES   = BLOCK_W / BYTE_W;
  localparam int NUM_WORDS   = BLOCK_W / WORD_W;
  localparam int NUM_ROUNDS  = 10;
  localparam int ROUND_CNT_W = $clog2(NUM_ROUNDS + 1);

  typedef logic [BYTE_W-1:0] byte_t;

  // strobes from the sequencer to the datapath and key stepper
  typedef struct packed {
    logic load;   // capture inputs, apply initial key addition
    logic step;   // perform one round
    logic last;   // this round omits the column mix
  } ctrlStrobes_t;

  function automatic byte_t xtime(byte_t a);
    byte_t r;
    r = {a[6:0], 1'b0};
    if (a[7]) r = r ^ 8'h1b;
    return r;
  endfunction

  function automatic byte_t gfMul(byte_t a, byte_t b);
    byte_t acc;
    byte_t x;
    acc = '0;
    x = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = xtime(x);
    end
    return acc;
  endfunction

  // substitution: multiplicative inverse as a^254, then affine map
  function automatic byte_t sbox(byte_t a);
    byte_t sq;
    byte_t inv;
    sq  = a;
    inv = 8'h01;
    for (int k = 1; k < BYTE_W; k++) begin
      sq  = gfMul(sq, sq);
      inv = gfMul(inv, sq);
    end
    return inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]}
               ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
  endfunction

  function automatic logic [WORD_W-1:0] subWord(logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int b = 0; b < WORD_W / BYTE_W; b++)
      r[b*BYTE_W +: BYTE_W] = sbox(w[b*BYTE_W +: BYTE_W]);
    return r;
  endfunction

endpackage

// File: rtl/aes_iter_ctrl.sv
module aes_iter_ctrl
  import aes_iter_pkg::*;
#(
  parameter int ROUNDS = NUM_ROUNDS
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t strobes,
  output logic         done
);

  localparam int CNT_W = $clog2(ROUNDS + 1);

  logic             busyQ;
  logic [CNT_W-1:0] roundQ;
  logic             doneQ;
  logic             acceptStart;
  logic             finalRound;

  assign acceptStart = start && !busyQ;
  assign finalRound  = busyQ && (roundQ == CNT_W'(ROUNDS));

  assign strobes.load = acceptStart;
  assign strobes.step = busyQ;
  assign strobes.last = finalRound;
  assign done         = doneQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      roundQ <= '0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (acceptStart) begin
        busyQ  <= 1'b1;
        roundQ <= CNT_W'(1);
      end else if (busyQ) begin
        if (finalRound) begin
          busyQ  <= 1'b0;
          roundQ <= '0;
          doneQ  <= 1'b1;
        end else begin
          roundQ <= roundQ + 1'b1;
        end
      end
    end
  end

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !finalRound) |=> (busyQ && !done));

  // R5
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start && !finalRound) |=> (roundQ == $past(roundQ) + 1'b1));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> (busyQ && roundQ == CNT_W'(1)));

  // R3
  round_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    roundQ <= CNT_W'(ROUNDS));

endmodule

// File: rtl/aes_key_stepper.sv
module aes_key_stepper
  import aes_iter_pkg::*;
#(
  parameter int KEY_W = BLOCK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [KEY_W-1:0] keyIn,
  output logic [KEY_W-1:0] nextKey
);

  localparam int WORDS = KEY_W / WORD_W;

  logic [KEY_W-1:0]  rkQ;
  byte_t             rconQ;
  logic [WORD_W-1:0] wOld [WORDS];
  logic [WORD_W-1:0] wNew [WORDS];
  logic [WORD_W-1:0] mixWord;

  assign mixWord = subWord({wOld[WORDS-1][WORD_W-BYTE_W-1:0],
                            wOld[WORDS-1][WORD_W-1 -: BYTE_W]})
                 ^ {rconQ, {(WORD_W-BYTE_W){1'b0}}};

  for (genvar gi = 0; gi < WORDS; gi++) begin : g_words
    assign wOld[gi] = rkQ[KEY_W-1-WORD_W*gi -: WORD_W];
    if (gi == 0) begin : g_first
      assign wNew[gi] = wOld[gi] ^ mixWord;
    end else begin : g_chain
      assign wNew[gi] = wOld[gi] ^ wNew[gi-1];
    end
    assign nextKey[KEY_W-1-WORD_W*gi -: WORD_W] = wNew[gi];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rkQ   <= '0;
      rconQ <= 8'h01;
    end else if (strobes.load) begin
      rkQ   <= keyIn;
      rconQ <= 8'h01;
    end else if (strobes.step && !strobes.last) begin
      rkQ   <= nextKey;
      rconQ <= xtime(rconQ);
    end
  end

  // R8
  rcon_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.last |-> (rconQ == 8'h36));

  // R8
  rcon_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($onehot(rconQ) || rconQ == 8'h1b || rconQ == 8'h36));

  // R8
  rcon_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> (rconQ == 8'h01));

endmodule

// File: rtl/aes_round_datapath.sv
module aes_round_datapath
  import aes_iter_pkg::*;
#(
  parameter int DATA_W = BLOCK_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] plainIn,
  input  logic [DATA_W-1:0] keyIn,
  input  logic [DATA_W-1:0] roundKey,
  output logic [DATA_W-1:0] stateOut
);

  localparam int NB   = DATA_W / BYTE_W;
  localparam int ROWS = 4;
  localparam int COLS = NB / ROWS;

  logic [DATA_W-1:0] stateQ;
  byte_t             subB    [NB];
  byte_t             shiftB  [NB];
  byte_t             mixB    [NB];
  logic [DATA_W-1:0] shiftV;
  logic [DATA_W-1:0] mixV;
  logic [DATA_W-1:0] roundOut;

  for (genvar gi = 0; gi < NB; gi++) begin : g_sub
    assign subB[gi] = sbox(stateQ[DATA_W-1-BYTE_W*gi -: BYTE_W]);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    for (genvar r = 0; r < ROWS; r++) begin : g_row
      assign shiftB[r + ROWS*c] = subB[r + ROWS*((c + r) % COLS)];
    end

    byte_t a0, a1, a2, a3;
    assign a0 = shiftB[ROWS*c];
    assign a1 = shiftB[ROWS*c + 1];
    assign a2 = shiftB[ROWS*c + 2];
    assign a3 = shiftB[ROWS*c + 3];

    assign mixB[ROWS*c]     = xtime(a0) ^ xtime(a1) ^ a1 ^ a2 ^ a3;
    assign mixB[ROWS*c + 1] = a0 ^ xtime(a1) ^ xtime(a2) ^ a2 ^ a3;
    assign mixB[ROWS*c + 2] = a0 ^ a1 ^ xtime(a2) ^ xtime(a3) ^ a3;
    assign mixB[ROWS*c + 3] = xtime(a0) ^ a0 ^ a1 ^ a2 ^ xtime(a3);
  end

  for (genvar gi = 0; gi < NB; gi++) begin : g_pack
    assign shiftV[DATA_W-1-BYTE_W*gi -: BYTE_W] = shiftB[gi];
    assign mixV[DATA_W-1-BYTE_W*gi -: BYTE_W]   = mixB[gi];
  end

  assign roundOut = (strobes.last ? shiftV : mixV) ^ roundKey;
  assign stateOut = stateQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= '0;
    end else if (strobes.load) begin
      stateQ <= plainIn ^ keyIn;
    end else if (strobes.step) begin
      stateQ <= roundOut;
    end
  end

  // R6
  state_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load || strobes.step) |=> $stable(stateQ));

  // R5
  no_double_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.load && strobes.step));

endmodule

// File: rtl/aes128_iter_core.sv
module aes128_iter_core
  import aes_iter_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [BLOCK_W-1:0] plainIn,
  input  logic [BLOCK_W-1:0] keyIn,
  output logic [BLOCK_W-1:0] cipherOut,
  output logic               done
);

  ctrlStrobes_t       strobes;
  logic [BLOCK_W-1:0] nextKey;

  aes_iter_ctrl #(.ROUNDS(NUM_ROUNDS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .done    (done)
  );

  aes_key_stepper #(.KEY_W(BLOCK_W)) u_keys (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .keyIn   (keyIn),
    .nextKey (nextKey)
  );

  aes_round_datapath #(.DATA_W(BLOCK_W)) u_data (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .plainIn  (plainIn),
    .keyIn    (keyIn),
    .roundKey (nextKey),
    .stateOut (cipherOut)
  );

endmodule

// File: tb/aes128_iter_core_bench.sv
module aes128_iter_core_bench;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [127:0] plainIn = '0;
  logic [127:0] keyIn = '0;
  logic [127:0] cipherOut;
  logic         done;

  int checks = 0;
  int errors = 0;
  logic [7:0] sbT [256];

  always #10 clk = ~clk;

  aes128_iter_core u_aes128_iter_core (
    .clk(clk), .rstN(rstN), .start(start), .plainIn(plainIn),
    .keyIn(keyIn), .cipherOut(cipherOut), .done(done)
  );

  // polynomial product then reduction by x^8+x^4+x^3+x+1
  function automatic logic [7:0] mulB(logic [7:0] a, logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (a[i]) p = p ^ (15'(b) << i);
    for (int j = 14; j >= 8; j--) if (p[j]) p = p ^ (15'h11b << (j - 8));
    return p[7:0];
  endfunction

  function automatic logic [127:0] refEnc(logic [127:0] pt, logic [127:0] key);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] k [16];
    logic [7:0] tmp [4];
    logic [7:0] u [4];
    logic [7:0] rc;
    logic [127:0] res;
    for (int i = 0; i < 16; i++) begin
      k[i] = key[127-8*i -: 8];
      s[i] = pt[127-8*i -: 8] ^ k[i];
    end
    rc = 8'h01;
    for (int rnd = 1; rnd <= 10; rnd++) begin
      tmp[0] = sbT[k[13]] ^ rc;
      tmp[1] = sbT[k[14]];
      tmp[2] = sbT[k[15]];
      tmp[3] = sbT[k[12]];
      for (int i = 0; i < 16; i++) k[i] = k[i] ^ ((i < 4) ? tmp[i] : k[i-4]);
      for (int i = 0; i < 16; i++) t[i] = sbT[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[r+4*c] = t[r+4*((c+r)%4)];
      if (rnd < 10) begin
        for (int c = 0; c < 4; c++) begin
          for (int j = 0; j < 4; j++) u[j] = s[4*c+j];
          s[4*c]   = mulB(8'h02, u[0]) ^ mulB(8'h03, u[1]) ^ u[2] ^ u[3];
          s[4*c+1] = u[0] ^ mulB(8'h02, u[1]) ^ mulB(8'h03, u[2]) ^ u[3];
          s[4*c+2] = u[0] ^ u[1] ^ mulB(8'h02, u[2]) ^ mulB(8'h03, u[3]);
          s[4*c+3] = mulB(8'h03, u[0]) ^ u[1] ^ u[2] ^ mulB(8'h02, u[3]);
        end
      end
      for (int i = 0; i < 16; i++) s[i] = s[i] ^ k[i];
      rc = mulB(rc, 8'h02);
    end
    for (int i = 0; i < 16; i++) res[127-8*i -: 8] = s[i];
    return res;
  endfunction

  task automatic check(string req, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // one encryption; disturb keeps start high and scrambles inputs while busy
  task automatic runOne(logic [127:0] pt, logic [127:0] key, logic [127:0] exp,
                        string tag, bit disturb);
    bit early;
    @(negedge clk);
    plainIn = pt; keyIn = key; start = 1'b1;
    @(negedge clk);                        // edge 0 has accepted start
    start = disturb;
    plainIn = rnd128(); keyIn = rnd128();  // R9: late input changes
    early = 1'b0;
    for (int k = 1; k < 10; k++) begin
      @(negedge clk);
      if (done) early = 1'b1;
      if (disturb) begin plainIn = rnd128(); keyIn = rnd128(); end
    end
    start = 1'b0;
    check({tag, " R3 no early done"}, 128'(early), 128'(0));
    @(negedge clk);                        // after edge 10
    check({tag, " R3 done at edge 10"}, 128'(done), 128'(1));
    check({tag, " R2 ciphertext"}, cipherOut, exp);
    @(negedge clk);
    check({tag, " R4 done one cycle"}, 128'(done), 128'(0));
    check({tag, " R6 output held"}, cipherOut, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] inv;
    logic [7:0] sv;
    logic [127:0] expA, expB, ptB;
    bit early;
    for (int x = 0; x < 256; x++) begin
      inv = 8'h00;
      for (int y = 1; y < 256; y++) if (mulB(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        sv[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^ inv[(i+7)%8]
              ^ ((8'h63 >> i) & 8'h01) != 0;
      sbT[x] = sv;
    end

    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 done in reset", 128'(done), 128'(0));
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    check("R1 idle without start", 128'(done), 128'(0));

    // R2: model anchored on known answers, then the core on them
    check("R2 model vector A",
      refEnc(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c),
      128'h3925841d02dc09fbdc118597196a0b32);
    check("R2 model vector B",
      refEnc(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f),
      128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    check("R2 model vector C", refEnc('0, '0), 128'h66e94bd4ef8a2c3b884cfa59ca342b2e);

    runOne(128'h3243f6a8885a308d313198a2e0370734, 128'h2b7e151628aed2a6abf7158809cf4f3c,
           128'h3925841d02dc09fbdc118597196a0b32, "kat A", 1'b0);
    runOne(128'h00112233445566778899aabbccddeeff, 128'h000102030405060708090a0b0c0d0e0f,
           128'h69c4e0d86a7b0430d8cdb78070b4c55a, "kat B", 1'b0);
    runOne('0, '0, 128'h66e94bd4ef8a2c3b884cfa59ca342b2e, "kat C", 1'b0);
    runOne('1, '1, refEnc('1, '1), "all ones", 1'b0);

    // R8, R9: random sweep checked by the bench model
    for (int n = 0; n < 40; n++) begin
      logic [127:0] p, k;
      p = rnd128(); k = rnd128();
      runOne(p, k, refEnc(p, k), "random R8", 1'b0);
    end

    // R5: start held high and inputs scrambled while busy
    for (int n = 0; n < 4; n++) begin
      logic [127:0] p, k;
      p = rnd128(); k = rnd128();
      runOne(p, k, refEnc(p, k), "busy start R5", 1'b1);
    end

    // R7: second start lands in the done cycle of the first
    plainIn = rnd128(); keyIn = rnd128();
    expA = refEnc(plainIn, keyIn);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 1; k < 10; k++) @(negedge clk);
    @(negedge clk);
    check("R7 first done", 128'(done), 128'(1));
    check("R7 first ciphertext", cipherOut, expA);
    ptB = rnd128();
    plainIn = ptB;
    expB = refEnc(ptB, keyIn);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 done drops", 128'(done), 128'(0));
    early = 1'b0;
    for (int k = 1; k < 10; k++) begin
      @(negedge clk);
      if (done) early = 1'b1;
    end
    check("R7 no early second done", 128'(early), 128'(0));
    @(negedge clk);
    check("R7 second done", 128'(done), 128'(1));
    check("R7 second ciphertext", cipherOut, expB);

    // R1: no start, no done
    early = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (done) early = 1'b1;
    end
    check("R1 quiet without start", 128'(early), 128'(0));
    check("R6 held while idle", cipherOut, expB);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule